// File: doc/BRIEF.md
# Predicated Execute and Flag-Write Gate

This block decides, in a single combinational step, whether the instruction now in the execute stage of a small two-operand processor takes effect. A three-bit predicate field is tested against the four status flags held in the low nibble of the condition-code register. The result gates three strobes: the register-file write enable, the memory-operation start, and the write enable of the status flags.

The flag-write rule depends on the instruction class. Compare and test instructions always refresh the flags, even when their predicate fails. Every other instruction refreshes the flags only when it is unconditional, is an arithmetic or logic operation, and writes to neither the program counter nor the condition-code register. Moves, bit-reverse and low-half immediate loads never touch the flags. The pins are plain control signals with no handshake. The surrounding pipeline presents one instruction's fields and samples the strobes in the same cycle.

Top module: `pred_gate`

## Requirements
- R1: `exec_o` is the predicate result. The `cond_i` encodings are 000 always true, 001 Z, 010 N (less-than), 011 C, 100 V, 101 not Z, 110 not N, 111 not C. The `flags_i` bits are Z at bit 0, C at bit 1, N at bit 2 and V at bit 3.
- R2: For an arithmetic/logic instruction (`cls_alu_i`), `reg_we_o` equals `exec_o`.
- R3: For a memory instruction (`cls_mem_i`), `mem_go_o` equals `exec_o`. `mem_go_o` is 0 for every other class.
- R4: For a compare/test instruction (`cls_cmp_i`), `flag_we_o` is 1 whatever the predicate and flags are, and `reg_we_o` is 0.
- R5: A non-compare instruction with `cond_i` other than 000 never sets `flag_we_o`.
- R6: An unconditional arithmetic/logic instruction whose `dst_i` is 15 (program counter) or 14 (condition-code register) does not set `flag_we_o`, but it still sets `reg_we_o`.
- R7: An unconditional arithmetic/logic instruction with `dst_i` in 0..13 sets `flag_we_o`.
- R8: For a move/bit-reverse/low-load instruction (`cls_mov_i`), `reg_we_o` equals `exec_o` and `flag_we_o` is 0.
- R9: With no class input asserted, `reg_we_o`, `flag_we_o` and `mem_go_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_i | input | 3 | Predicate field of the instruction |
| flags_i | input | 4 | Current status flags {V,N,C,Z} |
| cls_alu_i | input | 1 | Arithmetic/logic instruction that writes its result |
| cls_cmp_i | input | 1 | Compare or test instruction |
| cls_mov_i | input | 1 | Move, bit-reverse or low-half load |
| cls_mem_i | input | 1 | Load or store |
| dst_i | input | 4 | Destination register index |
| exec_o | output | 1 | Predicate holds |
| reg_we_o | output | 1 | Register-file write enable |
| flag_we_o | output | 1 | Status-flag write enable |
| mem_go_o | output | 1 | Start memory operation |

## Verification
The assertions take the four class inputs as mutually exclusive: at most one of them is high at any time, because the decoder upstream assigns each instruction exactly one class. The directed stimulus keeps to this. It raises at most one class pin per scenario, and it covers every predicate against all sixteen flag patterns. Destination indices sweep the full range, including both special registers.

// File: rtl/pred_gate_pkg.sv
package pred_gate_pkg;
  localparam int FLAG_W   = 4;
  localparam int FLAG_Z   = 0;
  localparam int FLAG_C   = 1;
  localparam int FLAG_N   = 2;
  localparam int FLAG_V   = 3;

  typedef enum logic [2:0] {
    PC_ALWAYS = 3'b000,
    PC_ZERO   = 3'b001,
    PC_NEG    = 3'b010,
    PC_CARRY  = 3'b011,
    PC_OVF    = 3'b100,
    PC_NZERO  = 3'b101,
    PC_NNEG   = 3'b110,
    PC_NCARRY = 3'b111
  } pred_e;

  typedef struct packed {
    logic alu;
    logic cmp;
    logic mov;
    logic mem;
  } cls_t;
endpackage

// File: rtl/pred_eval.sv
module pred_eval
  import pred_gate_pkg::*;
(
  input  logic [2:0]        cond_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              hit_o,
  output logic              always_o
);
  pred_e sel;
  logic  base;
  logic  inv;

  always_comb begin
    sel = pred_e'(cond_i);
    base = 1'b1;
    inv  = 1'b0;
    unique case (sel)
      PC_ALWAYS: begin base = 1'b1;             inv = 1'b0; end
      PC_ZERO:   begin base = flags_i[FLAG_Z];  inv = 1'b0; end
      PC_NEG:    begin base = flags_i[FLAG_N];  inv = 1'b0; end
      PC_CARRY:  begin base = flags_i[FLAG_C];  inv = 1'b0; end
      PC_OVF:    begin base = flags_i[FLAG_V];  inv = 1'b0; end
      PC_NZERO:  begin base = flags_i[FLAG_Z];  inv = 1'b1; end
      PC_NNEG:   begin base = flags_i[FLAG_N];  inv = 1'b1; end
      PC_NCARRY: begin base = flags_i[FLAG_C];  inv = 1'b1; end
      default:   begin base = 1'b1;             inv = 1'b0; end
    endcase
    hit_o    = base ^ inv;
    always_o = (sel == PC_ALWAYS);
  end
endmodule

// File: rtl/strobe_policy.sv
module strobe_policy
  import pred_gate_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15,
  parameter int CC_IDX = 14
) (
  input  logic             hit_i,
  input  logic             always_i,
  input  cls_t             cls_i,
  input  logic [IDX_W-1:0] dst_i,
  output logic             reg_we_o,
  output logic             flag_we_o,
  output logic             mem_go_o
);
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);
  localparam logic [IDX_W-1:0] CC_SEL = IDX_W'(CC_IDX);

  logic special_dst;

  always_comb begin
    special_dst = (dst_i == PC_SEL) || (dst_i == CC_SEL);
    reg_we_o    = hit_i & (cls_i.alu | cls_i.mov);
    mem_go_o    = hit_i & cls_i.mem;
    flag_we_o   = cls_i.cmp | (cls_i.alu & always_i & ~special_dst);
  end
endmodule

// File: rtl/pred_gate.sv
module pred_gate
  import pred_gate_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15,
  parameter int CC_IDX = 14
) (
  input  logic [2:0]       cond_i,
  input  logic [3:0]       flags_i,
  input  logic             cls_alu_i,
  input  logic             cls_cmp_i,
  input  logic             cls_mov_i,
  input  logic             cls_mem_i,
  input  logic [IDX_W-1:0] dst_i,
  output logic             exec_o,
  output logic             reg_we_o,
  output logic             flag_we_o,
  output logic             mem_go_o
);
  logic hit;
  logic uncond;
  cls_t cls;

  assign cls = '{alu: cls_alu_i, cmp: cls_cmp_i, mov: cls_mov_i, mem: cls_mem_i};

  pred_eval u_eval (
    .cond_i   (cond_i),
    .flags_i  (flags_i),
    .hit_o    (hit),
    .always_o (uncond)
  );

  strobe_policy #(
    .IDX_W  (IDX_W),
    .PC_IDX (PC_IDX),
    .CC_IDX (CC_IDX)
  ) u_policy (
    .hit_i     (hit),
    .always_i  (uncond),
    .cls_i     (cls),
    .dst_i     (dst_i),
    .reg_we_o  (reg_we_o),
    .flag_we_o (flag_we_o),
    .mem_go_o  (mem_go_o)
  );

  assign exec_o = hit;
endmodule

// File: rtl/pred_gate_chk.sv
module pred_gate_chk #(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15,
  parameter int CC_IDX = 14
) (
  input logic [2:0]       cond_i,
  input logic [3:0]       flags_i,
  input logic             cls_alu_i,
  input logic             cls_cmp_i,
  input logic             cls_mov_i,
  input logic             cls_mem_i,
  input logic [IDX_W-1:0] dst_i,
  input logic             exec_o,
  input logic             reg_we_o,
  input logic             flag_we_o,
  input logic             mem_go_o
);
  logic [3:0] cls_vec;
  assign cls_vec = {cls_alu_i, cls_cmp_i, cls_mov_i, cls_mem_i};

  always_comb begin
    if ($onehot0(cls_vec)) begin
      a_r1_always_exec: assert (cond_i != 3'b000 || exec_o);
      a_r2_alu_wb: assert (!cls_alu_i || (reg_we_o == exec_o));
      a_r3_mem_gate: assert (!mem_go_o || (cls_mem_i && exec_o));
      a_r4_cmp_flags: assert (!cls_cmp_i || (flag_we_o && !reg_we_o));
      a_r5_cond_noflags: assert (cls_cmp_i || cond_i == 3'b000 || !flag_we_o);
      a_r6_special_dst: assert (cls_cmp_i ||
        !(dst_i == IDX_W'(PC_IDX) || dst_i == IDX_W'(CC_IDX)) || !flag_we_o);
      a_r8_mov_noflags: assert (!cls_mov_i || !flag_we_o);
      a_r9_idle: assert (cls_vec != 4'b0000 || !(reg_we_o || flag_we_o || mem_go_o));
    end
  end
endmodule

bind pred_gate pred_gate_chk #(
  .IDX_W  (IDX_W),
  .PC_IDX (PC_IDX),
  .CC_IDX (CC_IDX)
) u_chk (
  .cond_i    (cond_i),
  .flags_i   (flags_i),
  .cls_alu_i (cls_alu_i),
  .cls_cmp_i (cls_cmp_i),
  .cls_mov_i (cls_mov_i),
  .cls_mem_i (cls_mem_i),
  .dst_i     (dst_i),
  .exec_o    (exec_o),
  .reg_we_o  (reg_we_o),
  .flag_we_o (flag_we_o),
  .mem_go_o  (mem_go_o)
);

// File: tb/pred_gate_tb_top.sv
module pred_gate_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cond;
  logic [3:0] flags;
  logic       c_alu, c_cmp, c_mov, c_mem;
  logic [3:0] dst;
  logic       exec, reg_we, flag_we, mem_go;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pred_gate dut_i (
    .cond_i(cond), .flags_i(flags),
    .cls_alu_i(c_alu), .cls_cmp_i(c_cmp), .cls_mov_i(c_mov), .cls_mem_i(c_mem),
    .dst_i(dst), .exec_o(exec), .reg_we_o(reg_we), .flag_we_o(flag_we),
    .mem_go_o(mem_go)
  );

  function automatic logic want_exec(input logic [2:0] c, input logic [3:0] f);
    case (c)
      3'd0: return 1'b1;
      3'd1: return f[0];
      3'd2: return f[2];
      3'd3: return f[1];
      3'd4: return f[3];
      3'd5: return !f[0];
      3'd6: return !f[2];
      default: return !f[1];
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cond=%0d flags=%b dst=%0d actual=%b expected=%b",
               tag, cond, flags, dst, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] c, input logic [3:0] f, input logic [3:0] cls,
                       input logic [3:0] d);
    @(negedge clk);
    cond = c; flags = f; {c_alu, c_cmp, c_mov, c_mem} = cls; dst = d;
    #2;
  endtask

  task automatic t_idle();
    for (int c = 0; c < 8; c++) begin
      apply(3'(c), 4'hF, 4'b0000, 4'd3);
      chk("R9 reg_we", reg_we, 1'b0);
      chk("R9 flag_we", flag_we, 1'b0);
      chk("R9 mem_go", mem_go, 1'b0);
    end
  endtask

  task automatic t_pred_alu();
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++) begin
        apply(3'(c), 4'(f), 4'b1000, 4'd2);
        chk("R1 exec", exec, want_exec(3'(c), 4'(f)));
        chk("R2 reg_we", reg_we, want_exec(3'(c), 4'(f)));
        chk(c == 0 ? "R7 flag_we" : "R5 flag_we", flag_we, c == 0);
        chk("R3 mem_go idle", mem_go, 1'b0);
      end
  endtask

  task automatic t_mem();
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f += 5) begin
        apply(3'(c), 4'(f), 4'b0001, 4'd6);
        chk("R3 mem_go", mem_go, want_exec(3'(c), 4'(f)));
        chk("R5 mem flag_we", flag_we, 1'b0);
        chk("R3 mem reg_we", reg_we, 1'b0);
      end
  endtask

  task automatic t_cmp();
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f += 3) begin
        apply(3'(c), 4'(f), 4'b0100, 4'(c + 8));
        chk("R4 flag_we", flag_we, 1'b1);
        chk("R4 reg_we", reg_we, 1'b0);
      end
  endtask

  task automatic t_mov();
    for (int c = 0; c < 8; c++) begin
      apply(3'(c), 4'b0101, 4'b0010, 4'd1);
      chk("R8 reg_we", reg_we, want_exec(3'(c), 4'b0101));
      chk("R8 flag_we", flag_we, 1'b0);
    end
  endtask

  task automatic t_dst();
    for (int d = 0; d < 16; d++) begin
      apply(3'd0, 4'b0000, 4'b1000, 4'(d));
      chk(d >= 14 ? "R6 flag_we" : "R7 flag_we", flag_we, d < 14);
      chk("R6 reg_we", reg_we, 1'b1);
    end
    apply(3'd1, 4'b0001, 4'b1000, 4'd15);
    chk("R6 cond pc flag_we", flag_we, 1'b0);
  endtask

  initial begin
    cond = '0; flags = '0; {c_alu, c_cmp, c_mov, c_mem} = '0; dst = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_pred_alu();
    t_mem();
    t_cmp();
    t_mov();
    t_dst();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule